// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This execution unit belongs to a 128-bit SIMD datapath. Each operand is split into four 32-bit lanes, and each lane holds four bytes. In every lane the unit multiplies the four bytes of operand A, taken as signed, by the matching four bytes of operand B, taken as unsigned. It adds the four products to the signed 32-bit word of operand C in the same lane. The low 32 bits of each lane sum form the lane's result. Overflow wraps silently and raises no flag.

The unit also receives the 32-bit instruction word and decodes it. A matching word with the vector facility enabled gives a result, tagged with the target register index in the unified 64-entry register space. A matching word with the facility disabled gives a vector-unavailable fault instead of a result. A word that does not match gives a separate no-match indication. The datapath has two pipeline stages: products in the first, lane sums in the second. The unit accepts one instruction per cycle.

Top module: `mxdot_unit`

## Requirements
- R1: Lane w (0 to 3) is bits [127-32w -: 32] of each operand, so word 0 is the most significant word. Byte j (0 to 3) of that lane is bits [127-32w-8j -: 8], so byte 0 is the most significant byte of its word. Result lane w depends only on lane w of A, B and C.
- R2: Each byte of A is sign-extended and each byte of B is zero-extended before multiplying, so a product lies between -32640 and +32385. The lane result is C's lane word, taken as signed, plus the four products.
- R3: Only the low 32 bits of each lane sum are returned. Sums above 2^31-1 or below -2^31 wrap, and no overflow or saturation flag is raised.
- R4: An instruction accepted at a rising edge (in_valid high) shows its outputs after the second following rising edge. Instructions may be issued back to back on every cycle.
- R5: A matching instruction with vec_en low asserts fault_vu, and res_valid stays low for it. At most one of res_valid, fault_vu and no_match is high in any cycle.
- R6: An instruction matches when instr[31:26] equals 4 and instr[5:0] equals 6'h25, whatever its other bits hold. A word that does not match asserts only no_match, whatever vec_en is.
- R7: res_tgt equals instr[25:21] plus 32. The source register fields instr[20:16], instr[15:11] and instr[10:6] have no effect on the result.
- R8: A synchronous active-high rst clears res_valid, fault_vu and no_match at the edge where it is sampled, and this includes instructions already in the pipeline.
- R9: A cycle with in_valid low produces no res_valid, fault_vu or no_match two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| vec_en | input | 1 | Vector facility enable |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | Signed-byte operand |
| src_b | input | 128 | Unsigned-byte operand |
| src_c | input | 128 | Signed 32-bit accumulator lanes |
| res_valid | output | 1 | res_data and res_tgt hold a result |
| res_data | output | 128 | Four wrapped 32-bit lane sums |
| res_tgt | output | 6 | Target index in the unified register space |
| fault_vu | output | 1 | Vector-unavailable fault |
| no_match | output | 1 | Instruction word not recognised |

## Verification
The main pattern is a streamed sweep that gives all 65,536 pairs of a signed A byte and an unsigned B byte, 16 pairs per instruction, with a different C value on every instruction. This sweep separates correct sign and zero extension from swapped or missing extension at the extreme values. Single nonzero bytes walked through all sixteen positions show whether each lane and byte sits at the right place. Saturated operands placed next to the positive and negative 32-bit limits show whether the sum wraps or clamps. Opcode words with one field changed, vec_en held low, idle cycles, and a reset while instructions are in flight show whether the decode and the dispatch of each instruction to a result, a fault or no-match are correct.

// File: rtl/mxdot_pkg.sv
package mxdot_pkg;
    localparam int LANES   = 4;
    localparam int BYTES   = 4;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = BYTES * BYTE_W;
    localparam int VEC_W   = LANES * WORD_W;
    localparam int PROD_W  = 2 * BYTE_W + 1;
    localparam int REG_W   = 5;
    localparam int TGT_W   = REG_W + 1;
    localparam int REG_OFS = 32;
    localparam int INSN_W  = 32;
    localparam int OP_W    = 6;
    localparam logic [OP_W-1:0] PRIM_OP = 6'd4;
    localparam logic [OP_W-1:0] EXT_OP  = 6'h25;

    typedef enum logic [1:0] {
        DISP_NONE,
        DISP_RESULT,
        DISP_FAULT,
        DISP_NOMATCH
    } disp_e;

    typedef struct packed {
        disp_e             disp;
        logic [TGT_W-1:0]  tgt;
    } slot_t;

    function automatic logic signed [PROD_W-1:0] mixmul(
        input logic [BYTE_W-1:0] sbyte,
        input logic [BYTE_W-1:0] ubyte
    );
        logic signed [PROD_W-1:0] sx;
        logic signed [PROD_W-1:0] zx;
        sx = {{(PROD_W-BYTE_W){sbyte[BYTE_W-1]}}, sbyte};
        zx = {{(PROD_W-BYTE_W){1'b0}}, ubyte};
        return sx * zx;
    endfunction
endpackage

// File: rtl/mxdot_decode.sv
module mxdot_decode
    import mxdot_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    input  logic              vec_en,
    output slot_t             slot
);
    logic hit;

    always_comb begin
        hit = (instr[INSN_W-1 -: OP_W] == PRIM_OP) && (instr[OP_W-1:0] == EXT_OP);
        slot.tgt = TGT_W'(instr[INSN_W-OP_W-1 -: REG_W]) + TGT_W'(REG_OFS);
        if (!hit)
            slot.disp = DISP_NOMATCH;
        else if (!vec_en)
            slot.disp = DISP_FAULT;
        else
            slot.disp = DISP_RESULT;
    end
endmodule

// File: rtl/mxdot_lane.sv
module mxdot_lane
    import mxdot_pkg::*;
(
    input  logic              clk,
    input  logic              cap1,
    input  logic              cap2,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [WORD_W-1:0] c_word,
    output logic [WORD_W-1:0] sum_q
);
    logic signed [PROD_W-1:0] prod_d [BYTES];
    logic signed [PROD_W-1:0] prod_q [BYTES];
    logic [WORD_W-1:0]        acc_q;
    logic [WORD_W-1:0]        sum_d;

    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        localparam int HI = WORD_W - 1 - j * BYTE_W;
        assign prod_d[j] = mixmul(a_word[HI -: BYTE_W], b_word[HI -: BYTE_W]);

        always_ff @(posedge clk) begin
            if (cap1) prod_q[j] <= prod_d[j];
        end
    end

    always_ff @(posedge clk) begin
        if (cap1) acc_q <= c_word;
    end

    always_comb begin
        sum_d = acc_q;
        for (int j = 0; j < BYTES; j++)
            sum_d = sum_d + {{(WORD_W-PROD_W){prod_q[j][PROD_W-1]}}, prod_q[j]};
    end

    always_ff @(posedge clk) begin
        if (cap2) sum_q <= sum_d;
    end
endmodule

// File: rtl/mxdot_unit.sv
module mxdot_unit
    import mxdot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              vec_en,
    input  logic [INSN_W-1:0] instr,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  src_c,
    output logic              res_valid,
    output logic [VEC_W-1:0]  res_data,
    output logic [TGT_W-1:0]  res_tgt,
    output logic              fault_vu,
    output logic              no_match
);
    slot_t dec_slot;
    slot_t s1_q;
    slot_t s2_q;
    logic  cap1;
    logic  cap2;

    mxdot_decode u_dec (
        .instr  (instr),
        .vec_en (vec_en),
        .slot   (dec_slot)
    );

    assign cap1 = in_valid && (dec_slot.disp == DISP_RESULT);
    assign cap2 = (s1_q.disp == DISP_RESULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '{disp: DISP_NONE, tgt: '0};
            s2_q <= '{disp: DISP_NONE, tgt: '0};
        end else begin
            s1_q.disp <= in_valid ? dec_slot.disp : DISP_NONE;
            s1_q.tgt  <= dec_slot.tgt;
            s2_q      <= s1_q;
        end
    end

    for (genvar w = 0; w < LANES; w++) begin : g_lane
        localparam int HI = VEC_W - 1 - w * WORD_W;
        mxdot_lane u_lane (
            .clk    (clk),
            .cap1   (cap1),
            .cap2   (cap2),
            .a_word (src_a[HI -: WORD_W]),
            .b_word (src_b[HI -: WORD_W]),
            .c_word (src_c[HI -: WORD_W]),
            .sum_q  (res_data[HI -: WORD_W])
        );
    end

    assign res_valid = (s2_q.disp == DISP_RESULT);
    assign fault_vu  = (s2_q.disp == DISP_FAULT);
    assign no_match  = (s2_q.disp == DISP_NOMATCH);
    assign res_tgt   = s2_q.tgt;
endmodule

// File: rtl/mxdot_chk.sv
module mxdot_chk
    import mxdot_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              vec_en,
    input logic [INSN_W-1:0] instr,
    input logic              res_valid,
    input logic [TGT_W-1:0]  res_tgt,
    input logic              fault_vu,
    input logic              no_match
);
    logic hit;
    assign hit = (instr[31:26] == 6'd4) && (instr[5:0] == 6'h25);

    // R4: an enabled matching instruction yields a result two edges later
    a_r4_result_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit && vec_en) |=> ##1 res_valid);

    // R5: disabled facility gives a fault and no result
    a_r5_fault_no_result: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit && !vec_en) |=> ##1 (fault_vu && !res_valid));

    // R5: the three outcomes exclude each other
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, fault_vu, no_match}));

    // R6: an unrecognised word gives only no_match
    a_r6_nomatch_only: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hit) |=> ##1 (no_match && !res_valid && !fault_vu));

    // R7: target index is the field plus the register-space offset
    a_r7_target: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_tgt == ({1'b0, $past(instr[25:21], 2)} + 6'd32)));

    // R9: an idle cycle leaves the outputs quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !(res_valid || fault_vu || no_match));
endmodule

bind mxdot_unit mxdot_chk u_chk (.*);

// File: tb/tb_mxdot_unit.sv
`timescale 1ns/1ps
module tb_mxdot_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         vec_en = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] src_c = '0;
    logic         res_valid;
    logic [127:0] res_data;
    logic [5:0]   res_tgt;
    logic         fault_vu;
    logic         no_match;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mxdot_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vec_en(vec_en), .instr(instr),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .res_valid(res_valid),
        .res_data(res_data), .res_tgt(res_tgt), .fault_vu(fault_vu), .no_match(no_match)
    );

    typedef struct {
        logic         v;
        logic         f;
        logic         n;
        logic [127:0] d;
        logic [5:0]   t;
        string        tag;
    } exp_t;

    exp_t e1, e2;

    function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] r;
        for (int w = 0; w < 4; w++) begin
            longint acc;
            acc = longint'($signed(c[127-32*w -: 32]));
            for (int j = 0; j < 4; j++) begin
                int hi;
                hi = 127 - 32*w - 8*j;
                acc = acc + longint'($signed(a[hi -: 8])) * longint'(b[hi -: 8]);
            end
            r[127-32*w -: 32] = acc[31:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] mk(logic [5:0] p, logic [4:0] t, logic [4:0] ra,
                                       logic [4:0] rb, logic [4:0] rc, logic [5:0] x);
        return {p, t, ra, rb, rc, x};
    endfunction

    function automatic exp_t idle_exp(string tag);
        exp_t e;
        e.v = 0; e.f = 0; e.n = 0; e.d = '0; e.t = '0; e.tag = tag;
        return e;
    endfunction

    task automatic check_out(exp_t e);
        n_cmp++;
        if ({res_valid, fault_vu, no_match} !== {e.v, e.f, e.n}) begin
            n_bad++;
            $display("FAIL %s flags v/f/n actual %b%b%b expected %b%b%b",
                     e.tag, res_valid, fault_vu, no_match, e.v, e.f, e.n);
        end
        if (e.v) begin
            n_cmp++;
            if (res_data !== e.d || res_tgt !== e.t) begin
                n_bad++;
                $display("FAIL %s data/tgt actual %h/%0d expected %h/%0d",
                         e.tag, res_data, res_tgt, e.d, e.t);
            end
        end
    endtask

    task automatic step(logic iv, logic ve, logic [31:0] ins, logic [127:0] a,
                        logic [127:0] b, logic [127:0] c, string tag);
        exp_t en;
        logic hit;
        @(negedge clk);
        check_out(e2);
        in_valid = iv; vec_en = ve; instr = ins; src_a = a; src_b = b; src_c = c;
        hit = (ins[31:26] == 6'd4) && (ins[5:0] == 6'h25);
        en = idle_exp(tag);
        if (iv) begin
            en.n = !hit;
            en.f = hit && !ve;
            en.v = hit && ve;
            en.d = model(a, b, c);
            en.t = {1'b0, ins[25:21]} + 6'd32;
        end
        e2 = e1;
        e1 = en;
    endtask

    task automatic drain();
        step(0, 1, '0, '0, '0, '0, "R9");
        step(0, 1, '0, '0, '0, '0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] a, b, c;
        e1 = idle_exp("R9");
        e2 = idle_exp("R9");
        // R8: reset state
        repeat (2) @(negedge clk);
        check_out(idle_exp("R8"));
        rst = 1'b0;

        // R1 R2: exhaustive signed x unsigned byte pairs, streamed back to back (R4)
        for (int n = 0; n < 4096; n++) begin
            for (int p = 0; p < 16; p++) begin
                logic [15:0] q;
                q = 16'(n * 16 + p);
                a[127-8*p -: 8] = q[15:8];
                b[127-8*p -: 8] = q[7:0];
            end
            c = {4{32'(n * 32'h9E3779B9)}};
            c[63:32] = ~c[63:32];
            step(1, 1, mk(6'd4, 5'(n), 5'(n >> 5), 5'(n >> 2), 5'(n * 7), 6'h25),
                 a, b, c, "R2");
        end
        drain();

        // R1: single byte walk to check lane and byte placement
        for (int p = 0; p < 16; p++) begin
            a = '0; a[127-8*p -: 8] = 8'(p + 1);
            b = {16{8'h03}};
            c = {32'd100, 32'd200, 32'd300, 32'd400};
            step(1, 1, mk(6'd4, 5'(p), 5'd0, 5'd0, 5'd0, 6'h25), a, b, c, "R1");
        end
        drain();

        // R3: wrap above and below the signed 32-bit range
        step(1, 1, mk(6'd4, 5'd1, 5'd2, 5'd3, 5'd4, 6'h25), {16{8'h7F}}, {16{8'hFF}},
             {4{32'h7FFFFF9C}}, "R3");
        step(1, 1, mk(6'd4, 5'd2, 5'd2, 5'd3, 5'd4, 6'h25), {16{8'h80}}, {16{8'hFF}},
             {4{32'h80000005}}, "R3");
        step(1, 1, mk(6'd4, 5'd3, 5'd2, 5'd3, 5'd4, 6'h25), {8{8'h7F, 8'h80}}, {16{8'hFF}},
             {32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h0}, "R3");
        drain();

        // R5: facility disabled
        step(1, 0, mk(6'd4, 5'd9, 5'd1, 5'd1, 5'd1, 6'h25), {16{8'h11}}, {16{8'h22}}, '0, "R5");
        step(1, 1, mk(6'd4, 5'd10, 5'd1, 5'd1, 5'd1, 6'h25), {16{8'h11}}, {16{8'h22}}, '0, "R5");
        step(1, 0, mk(6'd4, 5'd11, 5'd1, 5'd1, 5'd1, 6'h25), {16{8'h81}}, {16{8'h22}}, '1, "R5");
        drain();

        // R6: decode, with near-miss words and vec_en both ways
        step(1, 1, mk(6'd5, 5'd1, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '0, "R6");
        step(1, 0, mk(6'd0, 5'd1, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '0, "R6");
        step(1, 1, mk(6'd4, 5'd1, 5'd0, 5'd0, 5'd0, 6'h24), '1, '1, '0, "R6");
        step(1, 1, mk(6'd4, 5'd1, 5'd0, 5'd0, 5'd0, 6'h05), '1, '1, '0, "R6");
        step(1, 1, mk(6'h24, 5'd1, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '0, "R6");
        step(1, 1, mk(6'd4, 5'd31, 5'd31, 5'd31, 5'd31, 6'h25), '1, '1, '0, "R6");
        drain();

        // R7: target extremes, source fields varied with same data
        step(1, 1, mk(6'd4, 5'd0, 5'd31, 5'd0, 5'd17, 6'h25), {16{8'hF0}}, {16{8'h0F}}, '0, "R7");
        step(1, 1, mk(6'd4, 5'd31, 5'd0, 5'd31, 5'd2, 6'h25), {16{8'hF0}}, {16{8'h0F}}, '0, "R7");
        drain();

        // R9: idle cycles with a matching word on the bus
        step(0, 1, mk(6'd4, 5'd5, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '1, "R9");
        step(0, 0, mk(6'd4, 5'd5, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '1, "R9");
        drain();

        // R8: reset with instructions in flight
        step(1, 1, mk(6'd4, 5'd6, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '1, "R8");
        step(1, 0, mk(6'd4, 5'd7, 5'd0, 5'd0, 5'd0, 6'h25), '1, '1, '1, "R8");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check_out(idle_exp("R8"));
        @(negedge clk);
        check_out(idle_exp("R8"));
        rst = 1'b0;
        e1 = idle_exp("R8");
        e2 = idle_exp("R8");
        drain();
        step(0, 1, '0, '0, '0, '0, "R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule